// File: doc/BRIEF.md
# Line-21 Caption Waveform Inserter

This block sits in an NTSC-style luma path. It overwrites the caption line of each field with a self-generated caption waveform. The video timing logic provides a sample-clock enable, a start-of-line pulse, the current line number and a field flag. On line 21 of an odd field, or line 284 of an even field, the block ignores the pixel input. In its place it emits a complete caption line of 8-bit luma codes:

- blanking;
- a seven-cycle sinusoidal run-in that is phase-locked to the data bit clock;
- two blank bit periods;
- a start bit;
- two 7-bit characters, each followed by an odd-parity bit.

Every other line passes through with a one-sample delay.

Software loads four 7-bit byte registers through a simple write port. One pair serves odd fields and a second pair serves even fields. Buffering is a single stage. A write completed before a caption line starts is sent on that line. A pair that has not been written since it was last sent goes out as null characters. A write that lands during a caption line is parked and committed once the line ends, so the bits on the wire are never disturbed.

Bit timing comes from a phase accumulator advanced on each sample enable. Its increment is chosen so that exactly 32 bit periods fit in one line. The top four phase bits index a 16-step run-in sine.

Top module: `cc_line21_inserter`

## Requirements
- R1: After reset `y_o` is 0. On a line that is not a caption line, the `y_o` value registered on a sample enable equals the `pix_i` value presented with that enable.
- R2: A caption line is line 21 when `field_odd_i`=1, or line 284 when `field_odd_i`=0. Line 21 carries the odd pair (addresses 0 and 1). Line 284 carries the even pair (addresses 2 and 3). Line 21 of an even field and line 284 of an odd field pass through.
- R3: Sample k of a line is the k-th enabled sample counting from the one flagged by `sol_i`, starting at k=0. Sample k lies in bit period floor(k*32/SMP_PER_LINE), so a line holds 32 bit periods.
- R4: Caption-line codes are 60 for blanking and 140 for logic 1. Every caption-line sample lies within 60..140.
- R5: Bit periods 0 to 4 are blanking. Periods 5 to 11 each carry one full run-in cycle, which starts at 60 on the period's first sample and peaks at 140 at its centre.
- R6: Periods 12 and 13 are blanking, and period 14 is a start bit at 140.
- R7: Periods 15 to 22 carry byte 0 and periods 23 to 30 carry byte 1. Each byte is sent D0 first up to D6, followed by one parity bit that makes the count of ones in the 8 bits odd. Period 31 is blanking.
- R8: `wr_addr_i` 0 selects odd byte 0, 1 selects odd byte 1, 2 selects even byte 0 and 3 selects even byte 1.
- R9: A write made before a caption line begins is sent on that line, including a write made during the line just before it.
- R10: If neither register of the line's pair was written since that pair was last sent, the line sends null characters: data bits 0 and parity bits 1.
- R11: A write that arrives during a caption line leaves that line's bits unchanged. It is committed after the line ends and is sent on the pair's next caption line.
- R12: `pix_i` has no effect on `y_o` during a caption line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | Sample-clock enable |
| sol_i | input | 1 | First sample of a line, qualified by `smp_en_i` |
| line_i | input | LINE_W | Current line number, held for the whole line |
| field_odd_i | input | 1 | 1 in odd fields, 0 in even fields |
| pix_i | input | 8 | Incoming luma sample |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Byte register select |
| wr_data_i | input | 7 | Character data |
| y_o | output | 8 | Output luma sample |

## Verification
Caption lines are run with distinct character pairs, with a byte that has an even number of ones and with one that has an odd number. This separates the parity polarity, the bit order within a byte and the order of the two bytes. Pass-through lines use a ramp, and caption lines use a different ramp. A caption line number presented with the wrong field flag shows whether field selection is correct and whether pixels leak into the waveform. Repeated caption lines with no write in between must produce null characters, which tells the pending logic apart from simple reuse of the registers. A write made in the middle of a caption line must leave that line intact and appear on the following one.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int PIX_W      = 8;
  localparam int CHAR_BITS  = 7;
  localparam int NUM_REGS   = 4;
  localparam int ADDR_W     = $clog2(NUM_REGS);
  localparam int BITS_LINE  = 32;
  localparam int BIT_W      = $clog2(BITS_LINE);
  localparam int PH_W       = 16;
  localparam int LUT_W      = 4;
  localparam int RUNIN_CYC  = 7;
  localparam int PAUSE_BITS = 2;
  localparam int DATA_BITS  = 16;
  localparam int WT_W       = 9;

  // (1 - cos(2*pi*i/16)) / 2 scaled to 256
  function automatic logic [WT_W-1:0] sine_wt(input logic [LUT_W-1:0] idx);
    logic [LUT_W-1:0] m;
    m = idx[LUT_W-1] ? LUT_W'(5'd16 - {1'b0, idx}) : idx;
    case (m)
      4'd0:    sine_wt = 9'd0;
      4'd1:    sine_wt = 9'd10;
      4'd2:    sine_wt = 9'd37;
      4'd3:    sine_wt = 9'd79;
      4'd4:    sine_wt = 9'd128;
      4'd5:    sine_wt = 9'd177;
      4'd6:    sine_wt = 9'd219;
      4'd7:    sine_wt = 9'd246;
      default: sine_wt = 9'd256;
    endcase
  endfunction
endpackage

// File: rtl/cc_bit_clock.sv
module cc_bit_clock
  import cc_pkg::*;
#(
  parameter int SMP_PER_LINE = 858
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_en_i,
  input  logic             sol_i,
  output logic [BIT_W-1:0] bit_o,
  output logic [LUT_W-1:0] ph_idx_o
);
  localparam int unsigned INC = ((1 << PH_W) * BITS_LINE) / SMP_PER_LINE;

  logic [PH_W-1:0]  ph_q, ph_cur, ph_nxt;
  logic [BIT_W-1:0] bit_q, bit_cur;
  logic             carry;

  // position of the sample presented this cycle
  assign ph_cur  = sol_i ? '0 : ph_q;
  assign bit_cur = sol_i ? '0 : bit_q;
  assign {carry, ph_nxt} = {1'b0, ph_cur} + (PH_W+1)'(INC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      bit_q <= '0;
    end else if (smp_en_i) begin
      ph_q  <= ph_nxt;
      bit_q <= bit_cur + BIT_W'(carry);
    end
  end

  assign bit_o    = bit_cur;
  assign ph_idx_o = ph_cur[PH_W-1 -: LUT_W];

  a_r3_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en_i && !sol_i |=> (bit_q == $past(bit_q)) || (bit_q == $past(bit_q) + 1'b1));
endmodule

// File: rtl/cc_byte_regs.sv
module cc_byte_regs
  import cc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [CHAR_BITS-1:0] wr_data_i,
  input  logic                 hold_i,
  input  logic                 start_i,
  input  logic                 start_even_i,
  input  logic                 done_i,
  input  logic                 sel_even_i,
  output logic [CHAR_BITS-1:0] byte0_o,
  output logic [CHAR_BITS-1:0] byte1_o,
  output logic                 null_o
);
  logic [NUM_REGS-1:0][CHAR_BITS-1:0] reg_q, stg_q;
  logic [NUM_REGS-1:0] stg_v_q, hit, upd;
  logic [1:0]          pend_q, pend_set;
  logic                null_q;

  always_comb begin
    for (int a = 0; a < NUM_REGS; a++) begin
      hit[a] = wr_en_i && (wr_addr_i == ADDR_W'(a));
      upd[a] = !hold_i && (hit[a] || stg_v_q[a]);
    end
    pend_set[0] = upd[0] || upd[1];
    pend_set[1] = upd[2] || upd[3];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q   <= '0;
      stg_q   <= '0;
      stg_v_q <= '0;
    end else begin
      for (int a = 0; a < NUM_REGS; a++) begin
        if (hold_i) begin
          if (hit[a]) begin
            stg_q[a]   <= wr_data_i;
            stg_v_q[a] <= 1'b1;
          end
        end else if (hit[a]) begin
          reg_q[a]   <= wr_data_i;
          stg_v_q[a] <= 1'b0;
        end else if (stg_v_q[a]) begin
          reg_q[a]   <= stg_q[a];
          stg_v_q[a] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      null_q <= 1'b1;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (pend_set[p])                                    pend_q[p] <= 1'b1;
        else if (done_i && (sel_even_i == (p != 0)))        pend_q[p] <= 1'b0;
      end
      if (start_i) null_q <= !pend_q[start_even_i];
    end
  end

  assign byte0_o = sel_even_i ? reg_q[2] : reg_q[0];
  assign byte1_o = sel_even_i ? reg_q[3] : reg_q[1];
  assign null_o  = null_q;

  a_r11_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(reg_q));
  a_r10_pend_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !pend_q[$past(sel_even_i)]);
endmodule

// File: rtl/cc_wave_gen.sv
module cc_wave_gen
  import cc_pkg::*;
#(
  parameter int BLANK_LVL = 60,
  parameter int HIGH_LVL  = 140,
  parameter int RUNIN_BIT = 5
) (
  input  logic [BIT_W-1:0]     bit_i,
  input  logic [LUT_W-1:0]     ph_idx_i,
  input  logic [CHAR_BITS-1:0] byte0_i,
  input  logic [CHAR_BITS-1:0] byte1_i,
  input  logic                 null_i,
  output logic [PIX_W-1:0]     lvl_o
);
  localparam int RUNIN_END = RUNIN_BIT + RUNIN_CYC;
  localparam int START_BIT = RUNIN_END + PAUSE_BITS;
  localparam int DATA0     = START_BIT + 1;
  localparam int DATA_END  = DATA0 + DATA_BITS;
  localparam int SWING     = HIGH_LVL - BLANK_LVL;
  localparam int PROD_W    = PIX_W + WT_W;

  logic [PROD_W-1:0]    prod;
  logic [3:0]           d;
  logic [CHAR_BITS-1:0] chr;
  logic [7:0]           frame;
  logic                 dbit;

  always_comb begin
    prod  = PROD_W'(SWING) * PROD_W'(sine_wt(ph_idx_i));
    d     = 4'(bit_i - BIT_W'(DATA0));
    chr   = d[3] ? byte1_i : byte0_i;
    frame = {~(^chr), chr};
    dbit  = null_i ? (d[2:0] == 3'd7) : frame[d[2:0]];
    lvl_o = PIX_W'(BLANK_LVL);
    if (bit_i >= BIT_W'(RUNIN_BIT) && bit_i < BIT_W'(RUNIN_END))
      lvl_o = PIX_W'(BLANK_LVL) + PIX_W'(prod >> 8);
    else if (bit_i == BIT_W'(START_BIT))
      lvl_o = PIX_W'(HIGH_LVL);
    else if (bit_i >= BIT_W'(DATA0) && bit_i < BIT_W'(DATA_END))
      lvl_o = dbit ? PIX_W'(HIGH_LVL) : PIX_W'(BLANK_LVL);
  end
endmodule

// File: rtl/cc_line21_inserter.sv
module cc_line21_inserter
  import cc_pkg::*;
#(
  parameter int SMP_PER_LINE = 858,
  parameter int LINE_W       = 10,
  parameter int CC_LINE_ODD  = 21,
  parameter int CC_LINE_EVEN = 284,
  parameter int BLANK_LVL    = 60,
  parameter int HIGH_LVL     = 140,
  parameter int RUNIN_BIT    = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_en_i,
  input  logic                 sol_i,
  input  logic [LINE_W-1:0]    line_i,
  input  logic                 field_odd_i,
  input  logic [PIX_W-1:0]     pix_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [CHAR_BITS-1:0] wr_data_i,
  output logic [PIX_W-1:0]     y_o
);
  logic                 line_is_cc, cc_act_q, pair_even_q, cc_cur, sol_en;
  logic                 start, done, tx_null;
  logic [BIT_W-1:0]     bit_pos;
  logic [LUT_W-1:0]     ph_idx;
  logic [CHAR_BITS-1:0] b0, b1;
  logic [PIX_W-1:0]     lvl;

  assign line_is_cc = ( field_odd_i && line_i == LINE_W'(CC_LINE_ODD)) ||
                      (!field_odd_i && line_i == LINE_W'(CC_LINE_EVEN));
  assign sol_en = smp_en_i && sol_i;
  assign start  = sol_en && line_is_cc;
  assign done   = sol_en && cc_act_q;
  assign cc_cur = sol_i ? line_is_cc : cc_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_act_q    <= 1'b0;
      pair_even_q <= 1'b0;
    end else if (sol_en) begin
      cc_act_q    <= line_is_cc;
      pair_even_q <= !field_odd_i;
    end
  end

  cc_bit_clock #(.SMP_PER_LINE(SMP_PER_LINE)) u_clk (
    .clk_i, .rst_ni, .smp_en_i, .sol_i,
    .bit_o(bit_pos), .ph_idx_o(ph_idx)
  );

  cc_byte_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .hold_i(cc_act_q), .start_i(start), .start_even_i(!field_odd_i),
    .done_i(done), .sel_even_i(pair_even_q),
    .byte0_o(b0), .byte1_o(b1), .null_o(tx_null)
  );

  cc_wave_gen #(.BLANK_LVL(BLANK_LVL), .HIGH_LVL(HIGH_LVL), .RUNIN_BIT(RUNIN_BIT)) u_wave (
    .bit_i(bit_pos), .ph_idx_i(ph_idx), .byte0_i(b0), .byte1_i(b1),
    .null_i(tx_null), .lvl_o(lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       y_o <= '0;
    else if (smp_en_i) y_o <= cc_cur ? lvl : pix_i;
  end

  a_r1_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en_i && !cc_cur |=> y_o == $past(pix_i));
  a_r4_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en_i && cc_cur |=> (y_o >= PIX_W'(BLANK_LVL)) && (y_o <= PIX_W'(HIGH_LVL)));
  a_r12_start_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> cc_act_q);
endmodule

// File: tb/cc_line21_inserter_tb_top.sv
module cc_line21_inserter_tb_top;
  localparam int SPL = 512;
  localparam int SPB = SPL / 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_en = 1'b0, sol = 1'b0, field_odd = 1'b1, wr_en = 1'b0;
  logic [9:0] line = '0;
  logic [7:0] pix = '0;
  logic [1:0] wr_addr = '0;
  logic [6:0] wr_data = '0;
  logic [7:0] y;

  always #5 clk = ~clk;

  cc_line21_inserter #(.SMP_PER_LINE(SPL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_en_i(smp_en), .sol_i(sol),
    .line_i(line), .field_odd_i(field_odd), .pix_i(pix),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .y_o(y)
  );

  typedef struct {
    logic [7:0] v;
    bit         care;
    string      req;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   errs = 0, checks = 0;
  logic en_d = 1'b0;

  always @(posedge clk) en_d <= smp_en;

  // monitor
  always @(negedge clk) begin
    if (en_d && rst_n) begin
      checks++;
      if (q.size() == 0) begin
        errs++;
        $display("FAIL R3 unexpected sample: actual=%0d expected=none", y);
      end else begin
        e = q.pop_front();
        if (e.care && y !== e.v) begin
          errs++;
          $display("FAIL %s: actual=%0d expected=%0d", e.req, y, e.v);
        end else if (!e.care && (y < 8'd60 || y > 8'd140)) begin
          errs++;
          $display("FAIL R4 run-in range: actual=%0d expected=60..140", y);
        end
      end
    end
  end

  function automatic exp_t cc_model(int k, logic [6:0] b0, logic [6:0] b1, bit nul);
    exp_t r;
    int b, i, d;
    logic [6:0] c;
    logic v;
    b = k / SPB;
    i = k % SPB;
    r.care = 1'b1;
    r.v = 8'd60;
    r.req = "R5 pre-blank";
    if (b >= 5 && b <= 11) begin
      r.req = "R5 run-in";
      if (i == 0)            r.v = 8'd60;
      else if (i == SPB / 2) r.v = 8'd140;
      else                   r.care = 1'b0;
    end else if (b == 12 || b == 13) begin
      r.req = "R6 pause";
    end else if (b == 14) begin
      r.req = "R6 start";
      r.v = 8'd140;
    end else if (b >= 15 && b <= 30) begin
      d = b - 15;
      c = (d < 8) ? b0 : b1;
      if (d % 8 == 7) v = nul ? 1'b1 : ~(^c);
      else            v = nul ? 1'b0 : c[d % 8];
      r.req = nul ? "R10 null char" : "R7 char bit";
      r.v = v ? 8'd140 : 8'd60;
    end else if (b == 31) begin
      r.req = "R7 tail blank";
    end
    return r;
  endfunction

  // driver: one line of SPL samples, enable every other cycle
  task automatic run_line(input int ln, input bit odd, input bit is_cc,
                          input logic [6:0] b0, input logic [6:0] b1, input bit nul,
                          input bit mid_wr, input logic [1:0] wa0, input logic [6:0] wd0,
                          input logic [1:0] wa1, input logic [6:0] wd1, input int seed);
    exp_t x;
    for (int k = 0; k < SPL; k++) begin
      @(negedge clk);
      smp_en = 1'b1;
      sol = (k == 0);
      line = 10'(ln);
      field_odd = odd;
      wr_en = 1'b0;
      pix = 8'(k * 3 + seed);
      if (is_cc) x = cc_model(k, b0, b1, nul);
      else begin
        x.v = pix;
        x.care = 1'b1;
        x.req = (ln == 21 || ln == 284) ? "R2 wrong-field pass" : "R1 pass";
      end
      if (is_cc && x.req == "R5 pre-blank") x.req = "R12 pixel ignored";
      q.push_back(x);
      @(negedge clk);
      smp_en = 1'b0;
      sol = 1'b0;
      if (mid_wr && (k == 100 || k == 101)) begin
        wr_en = 1'b1;
        wr_addr = (k == 100) ? wa0 : wa1;
        wr_data = (k == 100) ? wd0 : wd1;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [6:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    #3_000_000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (y !== 8'd0) begin
      errs++;
      $display("FAIL R1 reset value: actual=%0d expected=0", y);
    end

    // R8: odd pair via addresses 0/1
    wr(2'd0, 7'h41);
    wr(2'd1, 7'h42);
    run_line(20, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 11);
    run_line(21, 1, 1, 7'h41, 7'h42, 0, 0, 0, 0, 0, 0, 50);   // R2 R7 R12
    run_line(20, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 23);
    run_line(21, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 77);           // R10 null
    run_line(21, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5);            // R2 even field line 21
    // R9: even pair written during line 283
    run_line(283, 0, 0, 0, 0, 0, 1, 2'd2, 7'h7F, 2'd3, 7'h01, 9);
    // R11: mid-line write keeps current bits
    run_line(284, 0, 1, 7'h7F, 7'h01, 0, 1, 2'd2, 7'h33, 2'd3, 7'h34, 200);
    run_line(283, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    run_line(284, 0, 1, 7'h33, 7'h34, 0, 0, 0, 0, 0, 0, 90);   // R11 committed
    run_line(283, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2);
    run_line(284, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 3);           // R10 after clear
    run_line(284, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4);           // R2 odd field line 284

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errs++;
      $display("FAIL R3 leftover samples: actual=%0d expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule